// File: doc/BRIEF.md
# Instruction Packet Collector with Loop-End Detection

The collector takes a stream of 32-bit instruction words, one per cycle when `in_valid` is high, and groups them into packets. A packet ends on a word whose parse field (bits [15:14]) reads binary 11. When a packet closes, the block reports several results for one cycle with a `pkt_done` pulse:
- the word count and the packet size in bytes;
- a two-bit hardware-loop-end code, taken from the parse fields of the first two words;
- one extended flag per word position, with the merged immediate for each extended position.

The block keeps the reported values until the next packet closes. Two faults end a packet early. A word flagged with `in_last` that does not close the packet reports the packet as incomplete. A packet that reaches `MAX_WORDS` words without closing reports an overflow. After an overflow the remaining words are discarded up to the next closing word.

The control is a three-state machine:
- `PC_WAIT` means no word of the current packet is held yet.
- `PC_COLLECT` means at least one word is held.
- `PC_DRAIN` means words are being discarded after an overflow.

These are the transitions:
- From WAIT or COLLECT, a closing word, an incomplete word or an ordinary word goes to WAIT, WAIT or COLLECT respectively.
- From WAIT or COLLECT, the `MAX_WORDS`-th non-closing word goes to DRAIN.
- From DRAIN, a closing word or any `in_last` word goes to WAIT.

Top module: `pkt_collector`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: A packet closes on an accepted word with bits [15:14] = 11. In the following cycle `pkt_done` is high for exactly one cycle, `word_count` equals the number of words in the packet, and `size_bytes` equals four times that count.
- R3: The loop code is encoded as 0 = none, 1 = loop 0, 2 = loop 1, 3 = both loops. A word carries a loop marker when bits [15:14] = 10. A one-word packet always reports 0.
- R4: In a two-word packet, a marker in word 0 gives code 1, and no marker gives code 0.
- R5: In a packet of three or more words, markers in words 0 and 1 give 3, word 1 alone gives 2, and word 0 alone gives 1. Markers in later words are ignored.
- R6: A non-closing word whose bits [31:28] = 0000 is an extender. The word after it sets `ext_flags[i]` at its own position i. Its immediate slot `ext_imm[32*i+31:32*i]` becomes {extender[27:16], extender[13:0], word[5:0]}. Positions that are not extended report flag 0 and immediate 0, and position 0 is never extended.
- R7: An accepted word with `in_last` high that does not close the packet produces a one-cycle `pkt_incomplete` pulse and no `pkt_done`. The next word starts a new packet.
- R8: When the `MAX_WORDS`-th word of a packet does not close it, `pkt_overflow` pulses for one cycle. Later words up to and including the next closing word (or an `in_last` word) are discarded without a `pkt_done`. At most one of `pkt_done`, `pkt_incomplete` and `pkt_overflow` is high in any cycle.
- R9: Between completions, `word_count`, `size_bytes`, `loop_code`, `ext_flags` and `ext_imm` hold their values. Cycles with `in_valid` low do not change the packet being collected.
- R10: Extenders chain. An extender that is itself extended is flagged, and it also extends the word after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_word` carries a word this cycle |
| in_last | input | 1 | This word is the last one the stream holds |
| in_word | input | 32 | Instruction word |
| pkt_done | output | 1 | One-cycle pulse when a packet has closed |
| pkt_incomplete | output | 1 | One-cycle pulse when the stream ran out mid-packet |
| pkt_overflow | output | 1 | One-cycle pulse when a packet exceeded `MAX_WORDS` |
| word_count | output | $clog2(MAX_WORDS+1) | Words in the last completed packet |
| size_bytes | output | $clog2(MAX_WORDS+1)+2 | Byte size of the last completed packet |
| loop_code | output | 2 | Loop-end code of the last completed packet |
| ext_flags | output | MAX_WORDS | Extended flag per word position |
| ext_imm | output | 32*MAX_WORDS | Merged immediate per word position |

## Verification
The assertions assume three things about the inputs:
- `in_word` is a defined value whenever `in_valid` is high.
- `in_last` only has meaning together with `in_valid`.
- Every packet begins from the WAIT state after reset.

The stimulus always drives a fully defined word with a valid strobe. It raises `in_last` only in cycles where `in_valid` is high, and it clears both strobes during idle gaps. Under these conditions every parse-field combination, including stray loop markers and extenders in the closing position, stays within what the properties describe.

// File: rtl/pc_pkg.sv
package pc_pkg;
    localparam int unsigned PC_WORD_W = 32;
    localparam int unsigned PC_LOW_W  = 6;
    localparam int unsigned PC_PAY_W  = PC_WORD_W - PC_LOW_W;

    localparam logic [1:0] PC_PAR_CLOSE = 2'b11;
    localparam logic [1:0] PC_PAR_LOOP  = 2'b10;
    localparam logic [3:0] PC_EXT_TAG   = 4'b0000;

    typedef enum logic [1:0] {
        PC_WAIT    = 2'd0,
        PC_COLLECT = 2'd1,
        PC_DRAIN   = 2'd2
    } pc_state_e;

    typedef enum logic [1:0] {
        LC_NONE  = 2'd0,
        LC_LOOP0 = 2'd1,
        LC_LOOP1 = 2'd2,
        LC_BOTH  = 2'd3
    } pc_loop_e;
endpackage

// File: rtl/pc_word_classify.sv
module pc_word_classify
    import pc_pkg::*;
(
    input  logic [PC_WORD_W-1:0] word,
    output logic                 is_close,
    output logic                 is_mark,
    output logic                 is_ext,
    output logic [PC_PAY_W-1:0]  payload,
    output logic [PC_LOW_W-1:0]  low_imm
);
    logic [1:0] par;

    always_comb begin
        par      = word[15:14];
        is_close = (par == PC_PAR_CLOSE);
        is_mark  = (par == PC_PAR_LOOP);
        is_ext   = (word[31:28] == PC_EXT_TAG) && !is_close;
        payload  = {word[27:16], word[13:0]};
        low_imm  = word[PC_LOW_W-1:0];
    end
endmodule

// File: rtl/pc_loop_decode.sv
module pc_loop_decode
    import pc_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic [CNT_W-1:0] count,
    input  logic             mark0,
    input  logic             mark1,
    output pc_loop_e         code
);
    always_comb begin
        if (count == CNT_W'(2)) begin
            code = mark0 ? LC_LOOP0 : LC_NONE;
        end else if (count >= CNT_W'(3)) begin
            code = pc_loop_e'({mark1, mark0});
        end else begin
            code = LC_NONE;
        end
    end
endmodule

// File: rtl/pc_slot_bank.sv
module pc_slot_bank #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned IMM_W = 32,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_first,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_flag,
    input  logic [IMM_W-1:0]       wr_imm,
    output logic [SLOTS-1:0]       nxt_flags,
    output logic [SLOTS*IMM_W-1:0] nxt_imm
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic             cur_flag;
        logic [IMM_W-1:0] cur_imm;
        logic             hit;

        assign hit = wr_en && (wr_idx == IDX_W'(i));

        always_comb begin
            if (hit) begin
                nxt_flags[i]                 = wr_flag;
                nxt_imm[i*IMM_W +: IMM_W]    = wr_imm;
            end else if (wr_en && wr_first) begin
                nxt_flags[i]                 = 1'b0;
                nxt_imm[i*IMM_W +: IMM_W]    = '0;
            end else begin
                nxt_flags[i]                 = cur_flag;
                nxt_imm[i*IMM_W +: IMM_W]    = cur_imm;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_flag <= 1'b0;
                cur_imm  <= '0;
            end else begin
                cur_flag <= nxt_flags[i];
                cur_imm  <= nxt_imm[i*IMM_W +: IMM_W];
            end
        end
    end
endmodule

// File: rtl/pkt_collector.sv
module pkt_collector
    import pc_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic                               in_last,
    input  logic [31:0]                        in_word,
    output logic                               pkt_done,
    output logic                               pkt_incomplete,
    output logic                               pkt_overflow,
    output logic [$clog2(MAX_WORDS+1)-1:0]     word_count,
    output logic [$clog2(MAX_WORDS+1)+1:0]     size_bytes,
    output logic [1:0]                         loop_code,
    output logic [MAX_WORDS-1:0]               ext_flags,
    output logic [32*MAX_WORDS-1:0]            ext_imm
);
    localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1);
    localparam int unsigned IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    pc_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic                 mark0_q, mark1_q;
    logic                 pend_ext_q;
    logic [PC_PAY_W-1:0]  pend_pay_q;

    logic                 c_close, c_mark, c_ext;
    logic [PC_PAY_W-1:0]  c_pay;
    logic [PC_LOW_W-1:0]  c_low;

    logic                 accept, first;
    logic [CNT_W-1:0]     pos, cnt_new;
    logic                 m0_new, m1_new, eff_pend;
    logic                 finish, incomp, ovf;
    logic [31:0]          slot_imm;
    pc_loop_e             lc;
    logic [MAX_WORDS-1:0]    bank_flags;
    logic [32*MAX_WORDS-1:0] bank_imm;

    pc_word_classify u_cls (
        .word     (in_word),
        .is_close (c_close),
        .is_mark  (c_mark),
        .is_ext   (c_ext),
        .payload  (c_pay),
        .low_imm  (c_low)
    );

    always_comb begin
        first    = (state_q == PC_WAIT);
        accept   = in_valid && (state_q != PC_DRAIN);
        pos      = first ? '0 : cnt_q;
        cnt_new  = pos + CNT_W'(1);
        m0_new   = first ? c_mark : mark0_q;
        m1_new   = (pos == CNT_W'(1)) ? c_mark : mark1_q;
        eff_pend = pend_ext_q && !first;
        slot_imm = eff_pend ? {pend_pay_q, c_low} : '0;
        finish   = accept && c_close;
        incomp   = accept && !c_close && in_last;
        ovf      = accept && !c_close && !in_last && (cnt_new == CNT_W'(MAX_WORDS));
    end

    pc_loop_decode #(.CNT_W(CNT_W)) u_loop (
        .count (cnt_new),
        .mark0 (m0_new),
        .mark1 (m1_new),
        .code  (lc)
    );

    pc_slot_bank #(.SLOTS(MAX_WORDS), .IMM_W(32)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_first  (first),
        .wr_idx    (pos[IDX_W-1:0]),
        .wr_flag   (eff_pend),
        .wr_imm    (slot_imm),
        .nxt_flags (bank_flags),
        .nxt_imm   (bank_imm)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PC_WAIT, PC_COLLECT: begin
                if (accept) begin
                    if (finish || incomp) state_d = PC_WAIT;
                    else if (ovf)         state_d = PC_DRAIN;
                    else                  state_d = PC_COLLECT;
                end
            end
            PC_DRAIN: begin
                if (in_valid && (c_close || in_last)) state_d = PC_WAIT;
            end
            default: state_d = PC_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PC_WAIT;
        else        state_q <= state_d;
    end

    // packet working state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            mark0_q    <= 1'b0;
            mark1_q    <= 1'b0;
            pend_ext_q <= 1'b0;
            pend_pay_q <= '0;
        end else if (accept) begin
            cnt_q      <= (finish || incomp || ovf) ? '0 : cnt_new;
            mark0_q    <= m0_new;
            mark1_q    <= m1_new;
            pend_ext_q <= c_ext;
            pend_pay_q <= c_pay;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_done       <= 1'b0;
            pkt_incomplete <= 1'b0;
            pkt_overflow   <= 1'b0;
            word_count     <= '0;
            size_bytes     <= '0;
            loop_code      <= '0;
            ext_flags      <= '0;
            ext_imm        <= '0;
        end else begin
            pkt_done       <= finish;
            pkt_incomplete <= incomp;
            pkt_overflow   <= ovf;
            if (finish) begin
                word_count <= cnt_new;
                size_bytes <= {cnt_new, 2'b00};
                loop_code  <= lc;
                ext_flags  <= bank_flags;
                ext_imm    <= bank_imm;
            end
        end
    end
endmodule

// File: rtl/pc_checker.sv
module pc_checker
    import pc_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic                           in_last,
    input logic [31:0]                    in_word,
    input logic                           pkt_done,
    input logic                           pkt_incomplete,
    input logic                           pkt_overflow,
    input logic [$clog2(MAX_WORDS+1)-1:0] word_count,
    input logic [1:0]                     loop_code,
    input logic [MAX_WORDS-1:0]           ext_flags,
    input logic [1:0]                     st
);
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_done, pkt_incomplete, pkt_overflow}));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (word_count >= 1) && (word_count <= MAX_WORDS));

    assert_single_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PC_WAIT) && in_valid && (in_word[15:14] == 2'b11)
        |=> pkt_done && (word_count == 1));

    assert_short_noloop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done && (word_count == 1) |-> loop_code == 2'd0);

    assert_two_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done && (word_count == 2) |-> !loop_code[1]);

    assert_first_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !ext_flags[0]);

    assert_incomplete_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_last && (in_word[15:14] != 2'b11) |=> !pkt_done);

    assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_overflow |=> !pkt_done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |-> $stable(word_count) && $stable(loop_code) && $stable(ext_flags));
endmodule

bind pkt_collector pc_checker #(.MAX_WORDS(MAX_WORDS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_last        (in_last),
    .in_word        (in_word),
    .pkt_done       (pkt_done),
    .pkt_incomplete (pkt_incomplete),
    .pkt_overflow   (pkt_overflow),
    .word_count     (word_count),
    .loop_code      (loop_code),
    .ext_flags      (ext_flags),
    .st             (state_q)
);

// File: tb/sim_pkt_collector.sv
`timescale 1ns/1ps
module sim_pkt_collector;
    localparam int MAXW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_last = 1'b0;
    logic [31:0]  in_word = '0;
    logic         pkt_done, pkt_incomplete, pkt_overflow;
    logic [2:0]   word_count;
    logic [4:0]   size_bytes;
    logic [1:0]   loop_code;
    logic [3:0]   ext_flags;
    logic [127:0] ext_imm;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pkt_collector #(.MAX_WORDS(MAXW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_word(in_word), .pkt_done(pkt_done), .pkt_incomplete(pkt_incomplete),
        .pkt_overflow(pkt_overflow), .word_count(word_count), .size_bytes(size_bytes),
        .loop_code(loop_code), .ext_flags(ext_flags), .ext_imm(ext_imm)
    );

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [3:0] top, logic [1:0] par, logic [5:0] low);
        return {top, 12'hA5C, par, 8'h3B, low};
    endfunction

    // behavioural reference model
    int unsigned  q[$];
    int           mode = 0;   // 0 idle, 1 collecting, 2 discarding
    logic         e_done, e_inc, e_ovf;
    logic [2:0]   e_cnt;
    logic [4:0]   e_size;
    logic [1:0]   e_loop;
    logic [3:0]   e_flags;
    logic [127:0] e_imm;

    function automatic logic marked(int unsigned w);
        return w[15:14] == 2'b10;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete(); mode = 0;
            e_done = 0; e_inc = 0; e_ovf = 0; e_cnt = 0; e_size = 0;
            e_loop = 0; e_flags = 0; e_imm = 0;
        end else begin
            e_done = 0; e_inc = 0; e_ovf = 0;
            if (in_valid) begin
                logic [31:0] w;
                w = in_word;
                if (mode == 2) begin
                    if (w[15:14] == 2'b11 || in_last) mode = 0;
                end else begin
                    q.push_back(w);
                    if (w[15:14] == 2'b11) begin
                        int n;
                        n = q.size();
                        e_done = 1;
                        e_cnt = 3'(n);
                        e_size = 5'(n * 4);
                        if (n == 2)      e_loop = {1'b0, marked(q[0])};
                        else if (n >= 3) e_loop = {marked(q[1]), marked(q[0])};
                        else             e_loop = 2'd0;
                        e_flags = 0; e_imm = 0;
                        for (int i = 1; i < n; i++) begin
                            logic [31:0] p, c;
                            p = q[i-1]; c = q[i];
                            if (p[31:28] == 4'h0) begin
                                e_flags[i] = 1'b1;
                                e_imm[i*32 +: 32] = {p[27:16], p[13:0], c[5:0]};
                            end
                        end
                        q.delete(); mode = 0;
                    end else if (in_last) begin
                        e_inc = 1; q.delete(); mode = 0;
                    end else if (q.size() == MAXW) begin
                        e_ovf = 1; q.delete(); mode = 2;
                    end else begin
                        mode = 1;
                    end
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "done", pkt_done, e_done);
            chk("R2", "count", word_count, e_cnt);
            chk("R2", "size", size_bytes, e_size);
            chk("R3", "loop", loop_code, e_loop);
            chk("R6", "flags", ext_flags, e_flags);
            chk("R6", "imm", ext_imm, e_imm);
            chk("R7", "incomplete", pkt_incomplete, e_inc);
            chk("R8", "overflow", pkt_overflow, e_ovf);
        end
    end

    task automatic put(logic [31:0] w, logic last);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_last = last;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "done", pkt_done, 0);
        chk("R1", "count", word_count, 0);
        chk("R1", "loop", loop_code, 0);
        chk("R1", "flags", {ext_flags, ext_imm}, 0);
        rst_n = 1'b1;

        // R2 / R3: one-word packet, loop marker impossible
        put(mk(4'h7, 2'b11, 6'h01), 0); idle();
        chk("R2", "one word done", {pkt_done, word_count, size_bytes}, {1'b1, 3'd1, 5'd4});
        chk("R3", "one word loop", loop_code, 0);

        // R4: two-word packets
        put(mk(4'h7, 2'b10, 6'h02), 0); put(mk(4'h7, 2'b11, 6'h03), 0); idle();
        chk("R4", "w0 marked", loop_code, 2'd1);
        put(mk(4'h7, 2'b01, 6'h02), 0); put(mk(4'h7, 2'b11, 6'h03), 0); idle();
        chk("R4", "unmarked", loop_code, 2'd0);

        // R5: three and four words
        put(mk(4'h7, 2'b10, 0), 0); put(mk(4'h7, 2'b10, 0), 0); put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R5", "both", loop_code, 2'd3);
        put(mk(4'h7, 2'b01, 0), 0); put(mk(4'h7, 2'b10, 0), 0); put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R5", "w1 only", loop_code, 2'd2);
        put(mk(4'h7, 2'b10, 0), 0); put(mk(4'h7, 2'b01, 0), 0); put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R5", "w0 only", loop_code, 2'd1);
        put(mk(4'h7, 2'b01, 0), 0); put(mk(4'h7, 2'b01, 0), 0); put(mk(4'h7, 2'b10, 0), 0);
        put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R5", "late marker ignored", {loop_code, word_count, size_bytes}, {2'd0, 3'd4, 5'd16});

        // R6: extender then closing word
        put(mk(4'h0, 2'b01, 6'h15), 0); put(mk(4'h7, 2'b11, 6'h2A), 0); idle();
        chk("R6", "ext flag", ext_flags, 4'b0010);
        chk("R6", "ext imm", ext_imm[63:32], {12'hA5C, 8'h3B, 6'h15, 6'h2A});
        chk("R6", "plain slot imm", ext_imm[31:0], 0);

        // R10: chained extenders
        put(mk(4'h0, 2'b01, 6'h11), 0); put(mk(4'h0, 2'b01, 6'h22), 0);
        put(mk(4'h7, 2'b11, 6'h33), 0); idle();
        chk("R10", "chain flags", ext_flags, 4'b0110);
        chk("R10", "chain imm2", ext_imm[95:64], {12'hA5C, 8'h3B, 6'h22, 6'h33});

        // R9: outputs hold across idle cycles, gaps do not disturb collection
        repeat (3) idle();
        chk("R9", "hold", {pkt_done, ext_flags, word_count}, {1'b0, 4'b0110, 3'd3});
        put(mk(4'h7, 2'b10, 0), 0); idle(); idle(); put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R9", "gap packet", {word_count, loop_code}, {3'd2, 2'd1});

        // R7: stream ends mid-packet
        put(mk(4'h7, 2'b01, 0), 0); put(mk(4'h7, 2'b01, 0), 1); idle();
        chk("R7", "incomplete", {pkt_incomplete, pkt_done, word_count}, {1'b1, 1'b0, 3'd2});
        put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R7", "restart", word_count, 3'd1);

        // R8: overflow then discard up to closing word
        for (int i = 0; i < MAXW; i++) put(mk(4'h7, 2'b10, 0), 0);
        idle();
        chk("R8", "overflow", {pkt_overflow, pkt_done}, 2'b10);
        put(mk(4'h7, 2'b01, 0), 0); put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R8", "discarded", {pkt_done, word_count}, {1'b0, 3'd1});
        put(mk(4'h7, 2'b10, 0), 0); put(mk(4'h7, 2'b11, 0), 0); idle();
        chk("R8", "recovered", {pkt_done, word_count, loop_code}, {1'b1, 3'd2, 2'd1});

        // mixed stream against the model
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            in_last  = in_valid && (($urandom % 25) == 0);
            in_word  = mk((($urandom % 3) == 0) ? 4'h0 : 4'h7, 2'($urandom % 4), 6'($urandom));
        end
        idle(); idle();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule